// File: doc/BRIEF.md
# Path-Comparison Timing Error Counter

This block estimates how often supply noise makes a long logic path miss timing. It drives one stimulus bit that toggles on every enabled cycle. The surrounding logic routes that bit through a very short path and through a very long logic and interconnect path. The results of both paths are captured and fed back to the block. Each compared cycle in which the two captured values differ counts as one timing error.

Errors accumulate in a wrapping 10-bit counter. The counter's most significant bit is brought out through a register as a slow square wave. One full period of that wave is 1024 errors, so the error rate follows from the average period measured against the clock frequency. The block runs on its own clock. Sweeping that clock and finding the frequency at which the rate reaches one error per million cycles gives the operating limit of the path.

Top module: `path_err_counter`

## Requirements
- R1: While reset is sampled high at a clock edge, the stimulus, the error count and the top-bit output are all 0 after that edge.
- R2: The stimulus output inverts at every clock edge where enable is high, and it holds its value at edges where enable is low.
- R3: At the first two enabled edges after reset, or after enable has been low, the path values are not compared, and a mismatch there adds nothing.
- R4: When the path values differ at a compared edge t, the error count rises by exactly one after edge t+1, provided enable is still high at t+1. The count never changes by any step other than +1, except through reset.
- R5: When both path values are equal at a compared edge, no error is counted, whether both are 0 or both are 1.
- R6: The error count is 10 bits wide and wraps from 1023 to 0.
- R7: At an edge where enable is low, the count does not change and any path mismatch is ignored. An error pending from the last enabled edge is also dropped.
- R8: The top-bit output equals bit 9 of the count one edge later. With an error counted on every cycle its rising edges are 1024 cycles apart, and with an error on every second cycle they are 2048 cycles apart.
- R9: A reset that arrives while an error is pending clears it, so that error is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the measurement, swept to find the operating limit |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enables toggling, comparison and counting |
| short_path_i | input | 1 | Captured result of the short path |
| long_path_i | input | 1 | Captured result of the long path |
| stim_o | output | 1 | Toggling stimulus launched into both paths |
| err_cnt_o | output | 10 | Wrapping error count |
| err_msb_o | output | 1 | Registered top bit of the count, for period measurement |

## Verification
On every cycle the assertions check these properties:
- the stimulus toggles or holds according to enable;
- no error appears during the two warm-up edges;
- every counted error stems from a real mismatch;
- the count only ever steps by +1 and stays frozen while disabled;
- the top-bit output rises only after the count has passed 512 and falls only after it has wrapped to 0.

The bench scenarios cover what needs a longer history. These are the exact latency from mismatch to count, the dropping of a pending error by disable or reset, the wrap at 1023, and the period of the top-bit output, measured in cycles for two error densities.

// File: rtl/path_err_pkg.sv
package path_err_pkg;

  // Default measurement widths
  localparam int unsigned PE_CNT_W_DEF  = 10;
  localparam int unsigned PE_WARMUP_DEF = 2;

  // Comparison outcome of one cycle
  typedef enum logic [1:0] {
    CMP_SKIPPED = 2'd0,   // not yet armed or disabled
    CMP_AGREE   = 2'd1,   // paths matched
    CMP_ERROR   = 2'd2    // paths disagreed
  } cmp_result_e;

  // True when the two captured path results differ
  function automatic logic pe_disagree(input logic short_v, input logic long_v);
    return short_v ^ long_v;
  endfunction

  // Classify one cycle from arm state and path values
  function automatic cmp_result_e pe_classify(input logic live, input logic short_v,
                                              input logic long_v);
    if (!live)                          return CMP_SKIPPED;
    else if (pe_disagree(short_v, long_v)) return CMP_ERROR;
    else                                return CMP_AGREE;
  endfunction

endpackage

// File: rtl/pe_stim_gen.sv
module pe_stim_gen (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic stim_o
);

  logic stim_q;

  // One transition per enabled cycle into both paths
  always_ff @(posedge clk_i) begin
    if (rst_i)     stim_q <= 1'b0;
    else if (en_i) stim_q <= ~stim_q;
  end

  assign stim_o = stim_q;

  // R2: toggles when enabled
  assert_stim_toggle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (stim_o != $past(stim_o)));

  // R2: holds when disabled
  assert_stim_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(stim_o));

endmodule

// File: rtl/pe_path_compare.sv
module pe_path_compare
  import path_err_pkg::*;
#(
  parameter int unsigned WARMUP_CYC = PE_WARMUP_DEF
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic short_path_i,
  input  logic long_path_i,
  output logic hit_o
);

  localparam int unsigned SW = $clog2(WARMUP_CYC + 2);
  localparam logic [SW-1:0] SETTLE_LIM = SW'(WARMUP_CYC);

  logic [SW-1:0] settle_q;
  logic          live_w;
  cmp_result_e   result_w;
  logic          hit_q;

  // Warm-up counter: restarts whenever enable is low
  assign live_w = (settle_q == SETTLE_LIM);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) settle_q <= '0;
    else if (!live_w)   settle_q <= settle_q + SW'(1);
  end

  assign result_w = pe_classify(live_w, short_path_i, long_path_i);

  // Registered mismatch flag; dropped when disabled
  always_ff @(posedge clk_i) begin
    if (rst_i)      hit_q <= 1'b0;
    else if (en_i)  hit_q <= (result_w == CMP_ERROR);
    else            hit_q <= 1'b0;
  end

  assign hit_o = hit_q;

  // R3: first warm-up edge produces no hit
  assert_warmup_first_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    ((WARMUP_CYC >= 1) && $rose(en_i)) |=> !hit_o);

  // R3: second warm-up edge produces no hit
  assert_warmup_second_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    ((WARMUP_CYC >= 2) && $rose(en_i)) |=> ##1 !hit_o);

  // R4: a hit always stems from a real mismatch
  assert_hit_from_mismatch_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_o && $past(!rst_i)) |-> ($past(short_path_i) != $past(long_path_i)));

  // R5: matching paths never produce a hit
  assert_agree_no_hit_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (short_path_i == long_path_i) |=> !hit_o);

endmodule

// File: rtl/pe_err_accum.sv
module pe_err_accum
  import path_err_pkg::*;
#(
  parameter int unsigned CNT_W = PE_CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             msb_o
);

  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             msb_q;
  logic             bump_w;

  // Wrapping increment
  function automatic logic [CNT_W-1:0] wrap_inc(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign bump_w = en_i && hit_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (bump_w) cnt_q <= wrap_inc(cnt_q);
  end

  // Registered top bit for clean period measurement
  always_ff @(posedge clk_i) begin
    if (rst_i) msb_q <= 1'b0;
    else       msb_q <= cnt_q[CNT_W-1];
  end

  assign cnt_o = cnt_q;
  assign msb_o = msb_q;

  // R4: count only steps by one
  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && !$stable(cnt_o)) |-> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

  // R7: frozen while disabled
  assert_count_freeze_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(cnt_o));

  // R8: top bit rises only after count reached half scale
  assert_msb_rise_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(msb_o) && $past(!rst_i)) |-> ($past(cnt_o) == HALF_CNT));

  // R6: top bit falls only after the wrap to zero
  assert_msb_fall_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(msb_o) && $past(!rst_i)) |-> ($past(cnt_o) == '0));

endmodule

// File: rtl/path_err_counter.sv
module path_err_counter
  import path_err_pkg::*;
#(
  parameter int unsigned CNT_W      = PE_CNT_W_DEF,
  parameter int unsigned WARMUP_CYC = PE_WARMUP_DEF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             short_path_i,
  input  logic             long_path_i,
  output logic             stim_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             err_msb_o
);

  // Named internal event: one error ready to be counted
  logic err_hit_w;

  pe_stim_gen u_stim (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .stim_o (stim_o)
  );

  pe_path_compare #(.WARMUP_CYC(WARMUP_CYC)) u_cmp (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .en_i         (en_i),
    .short_path_i (short_path_i),
    .long_path_i  (long_path_i),
    .hit_o        (err_hit_w)
  );

  pe_err_accum #(.CNT_W(CNT_W)) u_acc (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .hit_i (err_hit_w),
    .cnt_o (err_cnt_o),
    .msb_o (err_msb_o)
  );

  // R1: reset clears every output
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (!stim_o && (err_cnt_o == '0) && !err_msb_o));

  // R9: a pending error is dropped by reset
  assert_reset_drops_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (err_cnt_o == '0));

endmodule

// File: tb/test_path_err_counter.sv
`timescale 1ns/1ps
module test_path_err_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       sp = 1'b0;
  logic       lp = 1'b0;
  logic       stim;
  logic [9:0] cnt;
  logic       msb;

  always #2.5 clk = ~clk;

  path_err_counter i_path_err_counter (
    .clk_i(clk), .rst_i(rst), .en_i(en), .short_path_i(sp), .long_path_i(lp),
    .stim_o(stim), .err_cnt_o(cnt), .err_msb_o(msb)
  );

  typedef struct {
    int    stim_e;
    int    cnt_e;
    int    msb_e;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int rise_prev = 0;
  int rise_last = 0;
  int rise_n = 0;

  // Reference state built from the requirements
  int  r_stim = 0;
  int  r_cnt = 0;
  int  r_top = 0;
  int  r_runlen = 0;   // enabled edges since reset or disable
  bit  r_pending = 0;  // mismatch waiting to be counted

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Driver: apply one cycle and push what the outputs must show after the edge
  task automatic drive(bit r, bit e, bit s, bit l, string tag);
    exp_t it;
    @(negedge clk);
    rst = r; en = e; sp = s; lp = l;
    if (r) begin
      r_stim = 0; r_cnt = 0; r_top = 0; r_runlen = 0; r_pending = 0;
    end else begin
      r_top = (r_cnt >= 512) ? 1 : 0;
      if (!e) begin
        r_pending = 0;
        r_runlen = 0;
      end else begin
        if (r_pending) r_cnt = (r_cnt == 1023) ? 0 : r_cnt + 1;
        r_pending = (r_runlen >= 2) && (s != l);
        r_runlen = r_runlen + 1;
        r_stim = 1 - r_stim;
      end
    end
    it.stim_e = r_stim; it.cnt_e = r_cnt; it.msb_e = r_top; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: pop and compare just after each edge
  initial begin
    int prev_msb;
    prev_msb = 0;
    forever begin
      exp_t it;
      @(posedge clk);
      #1;
      cyc++;
      if (msb && prev_msb == 0) begin
        rise_prev = rise_last;
        rise_last = cyc;
        rise_n++;
      end
      prev_msb = int'(msb);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk((it.tag == "R1") ? "R1" : "R2", "stim", int'(stim), it.stim_e);
        chk(it.tag, "count", int'(cnt), it.cnt_e);
        chk((it.tag == "R1") ? "R1" : "R8", "msb", int'(msb), it.msb_e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (60000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    int k0;
    // R1: reset state
    repeat (3) drive(1, 0, 0, 0, "R1");
    // R5: equal paths, both polarities
    repeat (6) drive(0, 1, 0, 0, "R5");
    repeat (4) drive(0, 1, 1, 1, "R5");
    // R2/R7: disabled, stimulus holds
    repeat (2) drive(0, 0, 0, 0, "R7");
    // R3: mismatch from the first enabled edge; first two ignored
    repeat (6) drive(0, 1, 1, 0, "R3");
    // R7: mismatch while disabled, pending error dropped
    repeat (4) drive(0, 0, 0, 1, "R7");
    // R4: latency and single steps
    repeat (10) drive(0, 1, 0, 1, "R4");
    drive(0, 1, 0, 0, "R4");
    drive(0, 1, 1, 0, "R4");
    repeat (3) drive(0, 1, 0, 0, "R4");
    // R9: reset with an error pending
    repeat (4) drive(0, 1, 1, 0, "R9");
    drive(1, 1, 1, 0, "R9");
    repeat (3) drive(0, 1, 1, 0, "R9");
    drive(1, 0, 0, 0, "R1");
    // R6/R8: error every cycle, wraps twice
    k0 = rise_n;
    repeat (2200) drive(0, 1, 1, 0, "R6");
    repeat (3) drive(0, 0, 0, 0, "R7");
    n_checks++;
    if (rise_n - k0 < 2 || rise_last - rise_prev != 1024) begin
      n_fail++;
      $display("FAIL R8 period dense: actual=%0d expected=1024 (rises %0d)",
               rise_last - rise_prev, rise_n - k0);
    end
    // R8: error every second cycle
    drive(1, 0, 0, 0, "R1");
    k0 = rise_n;
    for (int i = 0; i < 2100; i++) begin
      drive(0, 1, 1, 0, "R4");
      drive(0, 1, 1, 1, "R5");
    end
    repeat (3) drive(0, 0, 0, 0, "R7");
    n_checks++;
    if (rise_n - k0 < 2 || rise_last - rise_prev != 2048) begin
      n_fail++;
      $display("FAIL R8 period sparse: actual=%0d expected=2048 (rises %0d)",
               rise_last - rise_prev, rise_n - k0);
    end
    // Drain the scoreboard
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule